// File: doc/BRIEF.md
# Bus-Attached Matrix Tile Front End

This block sits between a 32-bit AHB-Lite bus and a small matrix-multiply engine that works on 4x4 tiles of signed 8-bit values. The host writes eight operand rows to one address, four bytes per row. The first four rows form the left matrix and the next four form the right matrix. Once the eighth row is stored, the block stalls the bus. It streams the rows to the engine one per cycle and then waits for the engine to report that its sixteen 16-bit products are ready.

The block then packs neighbouring products two to a word and writes the eight words into an output FIFO, one per cycle. After the last word is stored, the bus is released. The host reads the words back from a second address. A write that arrives while unread results remain is refused with an error response, and its data is discarded.

Top module: `ahb_mm_slave`

## Requirements
- R1: After reset, hready is 1, hresp is 0, op_valid is 0 and hrdata is 0.
- R2: A write to OP_ADDR (default 0x00) with an OKAY response stores one 32-bit row. Byte b (bits 8b+7..8b) is column b. While fewer than eight rows are stored, hready stays 1 and op_valid stays 0.
- R3: The cycle after the data phase of the eighth row, hready goes low. It stays low until the last packed word is stored, which is eight cycles after the cycle in which res_done is sampled. It is high again in the next cycle.
- R4: Once the eighth row is stored, op_valid is 1 for eight consecutive cycles. op_data carries the rows in write order, starting with the first row written.
- R5: res_done is sampled only while the block waits for results. The block then captures res_data, where product k = 4*i+j sits at bits 16k+15..16k. A res_done at any other time has no effect.
- R6: The packer stores word w = {product 2w+1, product 2w}: the lower-numbered product is in bits 15..0 and the higher-numbered one is in bits 31..16. It stores one word per cycle, w = 0 to 7.
- R7: A read from RES_ADDR (default 0x04) returns the oldest stored word with OKAY and removes it. Words come back in the order w = 0 to 7.
- R8: A read from RES_ADDR while the output FIFO is empty returns 0 with an OKAY response.
- R9: A write accepted while the output FIFO is not empty gets a two-cycle ERROR: first hready=0 with hresp=1, then hready=1 with hresp=1. Its data is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | AW | Transfer address |
| htrans | input | 2 | Transfer type (bit 1 set means a real transfer) |
| hwrite | input | 1 | 1 for write, 0 for read |
| hwdata | input | 32 | Write data (data phase) |
| hrdata | output | 32 | Read data (data phase) |
| hready | output | 1 | Transfer done / bus stall |
| hresp | output | 1 | 0 OKAY, 1 ERROR |
| op_valid | output | 1 | Operand row valid toward the engine |
| op_data | output | 32 | Operand row toward the engine |
| res_done | input | 1 | Engine results ready (one-cycle pulse) |
| res_data | input | 256 | Sixteen 16-bit products |

## Verification
The hardest case to reach is a refused write. It needs results waiting in the output FIFO and a host that has drained only part of them. The stimulus runs a full tile, reads back three words, and then issues an operand write. It checks both cycles of the error response. It then reads the remaining five words to confirm the FIFO was untouched. Finally it runs a fresh tile and checks that the engine receives exactly the eight new rows, with no trace of the refused data.

// File: rtl/ahb_mm_slave.sv
module ahb_mm_slave #(
  parameter int N = 4,
  parameter int AW = 8,
  parameter logic [AW-1:0] OP_ADDR = 8'h00,
  parameter logic [AW-1:0] RES_ADDR = 8'h04
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [AW-1:0]     haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [31:0]       hwdata,
  output logic [31:0]       hrdata,
  output logic              hready,
  output logic              hresp,
  output logic              op_valid,
  output logic [31:0]       op_data,
  input  logic              res_done,
  input  logic [N*N*16-1:0] res_data
);
  localparam int DW = 32;
  localparam int IN_DEPTH = 2 * N;
  localparam int NWORD = N * N * 16 / DW;
  localparam int IPW = $clog2(IN_DEPTH);
  localparam int OPW = $clog2(NWORD);

  typedef enum logic [1:0] {S_IDLE, S_FEED, S_WAIT, S_PACK} st_t;
  st_t st;

  logic [DW-1:0] imem [IN_DEPTH];
  logic [DW-1:0] omem [NWORD];
  logic [IPW-1:0] wcnt, fidx;
  logic [OPW-1:0] pidx, owp, orp;
  logic [OPW:0] ocnt;
  logic [N*N*16-1:0] res_q;
  logic dp_v, dp_wr, dp_res, err1, err2;

  wire hit_op  = (haddr == OP_ADDR);
  wire hit_res = (haddr == RES_ADDR);
  wire acc     = hsel && (htrans == 2'b10 || htrans == 2'b11) && hready;
  wire bad_wr  = acc && hwrite && (ocnt != '0);
  wire push    = dp_v && dp_wr && !dp_res && hready;
  wire rd_dp   = dp_v && !dp_wr && dp_res;
  wire pop     = rd_dp && hready && (ocnt != '0);
  wire out_we  = (st == S_PACK);
  wire [DW-1:0] out_word = res_q[pidx*DW +: DW];

  assign hready   = (st == S_IDLE) && !err1;
  assign hresp    = err1 || err2;
  assign op_valid = (st == S_FEED);
  assign op_data  = imem[fidx];
  assign hrdata   = (rd_dp && ocnt != '0) ? omem[orp] : '0;

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      dp_v <= 1'b0; dp_wr <= 1'b0; dp_res <= 1'b0;
      err1 <= 1'b0; err2 <= 1'b0;
    end else begin
      err1 <= bad_wr;
      err2 <= err1;
      if (hready) begin
        dp_v   <= acc && !bad_wr && (hit_op || hit_res);
        dp_wr  <= hwrite;
        dp_res <= hit_res;
      end
    end
  end

  always_ff @(posedge hclk) begin
    if (push) imem[wcnt] <= hwdata;
    if (out_we) omem[owp] <= out_word;
    if (st == S_WAIT && res_done) res_q <= res_data;
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      st <= S_IDLE; wcnt <= '0; fidx <= '0; pidx <= '0;
    end else begin
      case (st)
        S_IDLE: if (push) begin
          if (wcnt == IPW'(IN_DEPTH - 1)) begin
            wcnt <= '0; fidx <= '0; st <= S_FEED;
          end else wcnt <= wcnt + 1'b1;
        end
        S_FEED: begin
          fidx <= fidx + 1'b1;
          if (fidx == IPW'(IN_DEPTH - 1)) st <= S_WAIT;
        end
        S_WAIT: if (res_done) begin
          pidx <= '0; st <= S_PACK;
        end
        S_PACK: begin
          pidx <= pidx + 1'b1;
          if (pidx == OPW'(NWORD - 1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      owp <= '0; orp <= '0; ocnt <= '0;
    end else begin
      if (out_we) owp <= owp + 1'b1;
      if (pop) orp <= orp + 1'b1;
      ocnt <= ocnt + (OPW+1)'(out_we) - (OPW+1)'(pop);
    end
  end

  // R3
  full_stall_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (push && wcnt == IPW'(IN_DEPTH - 1)) |=> (op_valid && !hready));
  // R4
  feed_stall_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    op_valid |-> !hready);
  // R6
  pack_room_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    out_we |-> (ocnt < (OPW+1)'(NWORD)));
  // R8
  empty_read_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (rd_dp && ocnt == '0) |-> (hrdata == '0 && !hresp));
  // R9
  err_seq_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (hresp && !hready) |=> (hresp && hready));
  // R9
  err_cause_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (hresp && !hready) |-> $past(hsel && hwrite && ocnt != '0));
endmodule

// File: tb/tb_ahb_mm_slave.sv
`timescale 1ns/1ps
module tb_ahb_mm_slave;
  localparam logic [7:0] OPA = 8'h00;
  localparam logic [7:0] RSA = 8'h04;

  logic clk = 1'b0, rstn = 1'b0;
  logic hsel = 0, hwrite = 0, res_done = 0;
  logic [7:0] haddr = 0;
  logic [1:0] htrans = 0;
  logic [31:0] hwdata = 0;
  logic [255:0] res_data = '0;
  logic [31:0] hrdata, op_data;
  logic hready, hresp, op_valid;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] rows [8];
  logic [31:0] seen [16];
  int seen_cyc [16];
  int seen_cnt = 0;
  logic [31:0] expw [8];

  ahb_mm_slave dut (
    .hclk(clk), .hresetn(rstn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
    .hresp(hresp), .op_valid(op_valid), .op_data(op_data),
    .res_done(res_done), .res_data(res_data));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (op_valid && seen_cnt < 16) begin
      seen[seen_cnt] = op_data; seen_cyc[seen_cnt] = cyc; seen_cnt++;
    end
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic ahb_write(input logic [7:0] a, input logic [31:0] d,
                           output bit r1, output bit rdy1, output bit rlast);
    @(negedge clk); hsel = 1; htrans = 2'b10; hwrite = 1; haddr = a;
    @(posedge clk);
    @(negedge clk); hsel = 0; htrans = 2'b00; hwdata = d;
    r1 = hresp; rdy1 = hready;
    while (!hready) @(negedge clk);
    rlast = hresp;
    @(posedge clk);
  endtask

  task automatic ahb_read(input logic [7:0] a, output logic [31:0] d, output bit r, output bit rdy);
    @(negedge clk); hsel = 1; htrans = 2'b10; hwrite = 0; haddr = a;
    @(posedge clk);
    @(negedge clk); hsel = 0; htrans = 2'b00;
    d = hrdata; r = hresp; rdy = hready;
    @(posedge clk);
  endtask

  function automatic logic [31:0] mkrow(int r, int seed);
    logic [31:0] v;
    for (int b = 0; b < 4; b++) v[8*b +: 8] = 8'(r * 37 + b * 91 + seed * 53 - 100);
    return v;
  endfunction

  task automatic build_results();
    logic [15:0] c [16];
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        int s = 0;
        for (int k = 0; k < 4; k++)
          s += int'($signed(rows[i][8*k +: 8])) * int'($signed(rows[4+k][8*j +: 8]));
        c[4*i+j] = 16'(s);
      end
    for (int k = 0; k < 16; k++) res_data[16*k +: 16] = c[k];
    for (int w = 0; w < 8; w++) expw[w] = {c[2*w+1], c[2*w]};
  endtask

  // Loads eight rows, checks feed and stall, completes packing; leaves results unread.
  task automatic run_tile(input int seed);
    bit r1, rdy1, rl;
    int lows, t;
    seen_cnt = 0;
    for (int r = 0; r < 8; r++) rows[r] = mkrow(r, seed);
    for (int r = 0; r < 7; r++) begin
      ahb_write(OPA, rows[r], r1, rdy1, rl);
      chk(!rl && rdy1, "R2 write okay", {30'b0, rdy1, rl}, 32'h2);
    end
    @(negedge clk);
    chk(hready && seen_cnt == 0, "R2 no stall before 8 rows", seen_cnt, 0);
    ahb_write(OPA, rows[7], r1, rdy1, rl);
    chk(!rl, "R2 eighth write okay", rl, 0);
    @(negedge clk);
    chk(!hready, "R3 stall after eighth row", hready, 0);
    t = 0;
    while (seen_cnt < 8 && t < 50) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(seen_cnt == 8, "R4 row count", seen_cnt, 8);
    chk(seen_cyc[7] - seen_cyc[0] == 7, "R4 consecutive rows", seen_cyc[7] - seen_cyc[0], 7);
    for (int r = 0; r < 8; r++) chk(seen[r] == rows[r], "R4 row order", seen[r], rows[r]);
    lows = 0;
    repeat (5) begin @(negedge clk); if (!hready) lows++; end
    chk(lows == 5, "R3 stall held while waiting", lows, 5);
    build_results();
    res_done = 1;
    lows = 0;
    @(negedge clk); res_done = 0;
    if (!hready) lows++;
    t = 0;
    while (!hready && t < 50) begin @(negedge clk); if (!hready) lows++; t++; end
    chk(lows == 8, "R3 release after eighth packed word", lows, 8);
  endtask

  task automatic read_words(input int from, input int n);
    logic [31:0] d; bit r, rdy;
    for (int w = from; w < from + n; w++) begin
      ahb_read(RSA, d, r, rdy);
      chk(d == expw[w] && !r, "R6 R7 packed word", d, expw[w]);
    end
  endtask

  task automatic test_reset();
    chk(hready && !hresp && !op_valid && hrdata == 0, "R1 reset state",
        {hrdata[28:0], hready, hresp, op_valid}, 32'h4);
  endtask

  task automatic test_empty_read();
    logic [31:0] d; bit r, rdy;
    ahb_read(RSA, d, r, rdy);
    chk(d == 0 && !r && rdy, "R8 empty read", d, 0);
  endtask

  task automatic test_stray_done();
    logic [31:0] d; bit r, rdy;
    @(negedge clk); res_data = {8{32'hA5A5_5A5A}}; res_done = 1;
    @(negedge clk); res_done = 0;
    chk(hready, "R5 stray done no stall", hready, 1);
    repeat (2) @(negedge clk);
    ahb_read(RSA, d, r, rdy);
    chk(d == 0 && !r, "R5 stray done ignored", d, 0);
  endtask

  task automatic test_full_tile();
    logic [31:0] d; bit r, rdy;
    run_tile(1);
    read_words(0, 8);
    ahb_read(RSA, d, r, rdy);
    chk(d == 0 && !r, "R8 read after drain", d, 0);
  endtask

  task automatic test_error();
    bit r1, rdy1, rl;
    run_tile(2);
    read_words(0, 3);
    ahb_write(OPA, 32'hDEAD_BEEF, r1, rdy1, rl);
    chk(r1 && !rdy1, "R9 error first cycle", {30'b0, rdy1, r1}, 32'h1);
    chk(rl, "R9 error second cycle", rl, 1);
    read_words(3, 5);
    run_tile(3);
    read_words(0, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstn = 1;
    repeat (2) @(negedge clk);
    test_reset();
    test_empty_read();
    test_stray_done();
    test_full_tile();
    test_error();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule